// File: doc/BRIEF.md
# Sensor Select and Pulse Capture

This block scans four sensor drivers one at a time. A two-bit select register steps to the next sensor each time the active-low frame strobe returns high. A decoder turns that select into one-hot enables, and only while the decoder-enable input is high. The same select steers a four-way multiplexer, so the pulse line routed onward always belongs to the sensor that is currently enabled.

The sensor pulse lines are asynchronous to the block clock. A two-flop synchronizer brings them into the clock domain before the multiplexer. The multiplexer output is gated with the settle-window input, so pulses from the unsettled start of each enable window are dropped. The qualified pulse is registered, and a saturating counter counts the clocks in which it is high.

In the usual use, a frame controller lowers the strobe once every 16 clocks. It raises decoder-enable for three clocks and raises the settle window on the last of those three. Each sensor then gets a 3-clock enable in every 64 clocks.

Top module: `sensor_scan_capture`

## Requirements
- R1: The select resets to 0 and advances by one in the clock after each low-to-high transition of `clr2_n` is sampled. It steps 0, 1, 2, 3 and then wraps to 0. It holds at all other times.
- R2: While `dec_en` is high, exactly one enable is high: select value 0 drives `sense_en[0]`, 1 drives `sense_en[1]`, 2 drives `sense_en[2]` and 3 drives `sense_en[3]`. The enables are combinational from the select and `dec_en`.
- R3: While `dec_en` is low, all four enables are low.
- R4: With `clr2_n` low in one clock of every 16 and `dec_en` high for three clocks of every 16, placed after the strobe, each enable is high for exactly 3 of any 64 frame-aligned clocks.
- R5: The multiplexer uses the same select as the decoder. Pulses on sensors that are not selected never reach `qual_pulse`.
- R6: `qual_pulse` is high in the clock after an edge at which both `sys` and the synchronized selected pulse are high. The synchronized pulse is the value of the sensor input sampled two edges earlier.
- R7: `pulse_count` increases by one in the clock after each clock in which `qual_pulse` is high.
- R8: `pulse_count` saturates at 2^CNT_W-1 and does not wrap.
- R9: An active-low `rst_n` clears the count, the qualified pulse, the synchronizer and the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr2_n | input | 1 | Active-low frame strobe; its rising edge steps the select |
| dec_en | input | 1 | Decoder enable window |
| sys | input | 1 | Settle window that qualifies the multiplexer output |
| sense_pulse | input | NUM_SENS (4) | Asynchronous sensor pulse lines |
| sense_en | output | NUM_SENS (4) | One-hot sensor enables |
| qual_pulse | output | 1 | Registered qualified pulse |
| pulse_count | output | CNT_W (8) | Saturating count of qualified pulse clocks |

## Verification
The enables are combinational, so they are checked in the same clock that `dec_en` is driven. The select is the exception: it takes one extra edge after a strobe rising edge is sampled. A sensor pulse needs three edges to reach `qual_pulse` (two synchronizer stages and the output register), and `sys` is taken at the third of those edges. The count follows one edge after that. The bench's behavioural model keeps a two-deep queue for the synchronizer and updates at each rising edge. The outputs are compared with the model at every falling edge, so each result is checked in the exact clock in which it is due.

// File: rtl/sscap_pkg.sv
package sscap_pkg;
    localparam int unsigned SENS_DEFAULT = 4;
    localparam int unsigned CNT_DEFAULT  = 8;

    // next-state record of the top-level output stage
    typedef struct packed {
        logic qual;
    } qual_state_t;
endpackage

// File: rtl/sscap_sync.sv
module sscap_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stage2;
endmodule

// File: rtl/sscap_selstep.sv
module sscap_selstep #(
    parameter int unsigned NUM   = 4,
    parameter int unsigned SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_n,
    output logic [SEL_W-1:0] sel
);
    localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM - 1);

    typedef struct packed {
        logic             strobe_prev;
        logic [SEL_W-1:0] sel;
    } step_state_t;

    step_state_t st_d, st_q;
    logic        rise;

    always_comb begin
        st_d             = st_q;
        rise             = strobe_n && !st_q.strobe_prev;
        st_d.strobe_prev = strobe_n;
        if (rise) begin
            if (st_q.sel == LAST) st_d.sel = '0;
            else                  st_d.sel = st_q.sel + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.strobe_prev <= 1'b1;
            st_q.sel         <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = st_q.sel;
endmodule

// File: rtl/sscap_satcount.sv
module sscap_satcount #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc && (st_q.cnt != TOP)) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/sensor_scan_capture.sv
module sensor_scan_capture
    import sscap_pkg::*;
#(
    parameter int unsigned NUM_SENS = SENS_DEFAULT,
    parameter int unsigned CNT_W    = CNT_DEFAULT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr2_n,
    input  logic                dec_en,
    input  logic                sys,
    input  logic [NUM_SENS-1:0] sense_pulse,
    output logic [NUM_SENS-1:0] sense_en,
    output logic                qual_pulse,
    output logic [CNT_W-1:0]    pulse_count
);
    localparam int unsigned SEL_W = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1;

    logic [SEL_W-1:0]    sel;
    logic [NUM_SENS-1:0] pulse_sync;
    logic                routed;
    qual_state_t         oq_d, oq_q;

    sscap_selstep #(.NUM(NUM_SENS), .SEL_W(SEL_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (clr2_n),
        .sel      (sel)
    );

    sscap_sync #(.W(NUM_SENS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sense_pulse),
        .sync_out (pulse_sync)
    );

    // decoder: one enable per select value, gated by the window
    for (genvar g = 0; g < NUM_SENS; g++) begin : g_dec
        assign sense_en[g] = dec_en && (sel == SEL_W'(g));
    end

    // multiplexer steered by the same select
    always_comb begin
        routed = 1'b0;
        for (int i = 0; i < NUM_SENS; i++) begin
            if (sel == SEL_W'(i)) routed = pulse_sync[i];
        end
    end

    always_comb begin
        oq_d      = oq_q;
        oq_d.qual = routed && sys;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) oq_q <= '0;
        else        oq_q <= oq_d;
    end

    assign qual_pulse = oq_q.qual;

    sscap_satcount #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (oq_q.qual),
        .count (pulse_count)
    );
endmodule

// File: rtl/sensor_scan_capture_chk.sv
module sensor_scan_capture_chk #(
    parameter int unsigned NUM_SENS = 4,
    parameter int unsigned CNT_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dec_en,
    input logic                sys,
    input logic [NUM_SENS-1:0] sense_en,
    input logic                qual_pulse,
    input logic [CNT_W-1:0]    pulse_count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    assert_onehot_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> $countones(sense_en) == 1);

    assert_quiet_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |-> sense_en == '0);

    assert_qual_needs_sys_R6: assert property (@(posedge clk) disable iff (!rst_n)
        qual_pulse |-> $past(sys));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_pulse && pulse_count != TOP) |=> pulse_count == $past(pulse_count) + 1'b1);

    assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_pulse |=> $stable(pulse_count));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_count == TOP |=> pulse_count == TOP);
endmodule

bind sensor_scan_capture sensor_scan_capture_chk #(
    .NUM_SENS(NUM_SENS),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_en     (dec_en),
    .sys        (sys),
    .sense_en   (sense_en),
    .qual_pulse (qual_pulse),
    .pulse_count(pulse_count)
);

// File: tb/sensor_scan_capture_tb.sv
module sensor_scan_capture_tb;
    localparam int CW  = 4;
    localparam int MAXC = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr2_n = 1'b1;
    logic       dec_en = 1'b0;
    logic       sys = 1'b0;
    logic [3:0] sense_pulse = '0;
    logic [3:0] sense_en;
    logic       qual_pulse;
    logic [CW-1:0] pulse_count;

    int checks = 0;
    int errors = 0;

    // reference model state
    int        m_sel;
    bit        m_prev;
    bit [3:0]  m_q[$];
    bit        m_qual;
    int        m_cnt;

    always #2.5 clk = ~clk;

    sensor_scan_capture #(.NUM_SENS(4), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr2_n(clr2_n), .dec_en(dec_en), .sys(sys),
        .sense_pulse(sense_pulse), .sense_en(sense_en),
        .qual_pulse(qual_pulse), .pulse_count(pulse_count)
    );

    task automatic model_reset();
        m_sel = 0; m_prev = 1'b1; m_q = {4'b0, 4'b0}; m_qual = 1'b0; m_cnt = 0;
    endtask

    task automatic model_edge();
        bit [3:0] s2;
        bit       nq;
        if (!rst_n) begin
            model_reset();
            return;
        end
        s2 = m_q[0];
        nq = s2[m_sel] && sys;
        if (m_qual && m_cnt < MAXC) m_cnt++;
        m_qual = nq;
        if (clr2_n && !m_prev) m_sel = (m_sel + 1) % 4;
        m_prev = clr2_n;
        void'(m_q.pop_front());
        m_q.push_back(sense_pulse);
    endtask

    task automatic compare(string tag);
        logic [3:0] exp_en;
        exp_en = dec_en ? (4'b1 << m_sel) : 4'b0;
        checks++;
        if (sense_en !== exp_en) begin
            errors++;
            $display("FAIL %s sense_en actual %b expected %b", dec_en ? "R2/R1" : "R3", sense_en, exp_en);
        end
        checks++;
        if (qual_pulse !== m_qual) begin
            errors++;
            $display("FAIL R6/R5 %s qual_pulse actual %b expected %b", tag, qual_pulse, m_qual);
        end
        checks++;
        if (int'(pulse_count) != m_cnt) begin
            errors++;
            $display("FAIL R7/R8 %s pulse_count actual %0d expected %0d", tag, pulse_count, m_cnt);
        end
    endtask

    // drive at the falling edge, compare, then let the model take the rising edge
    task automatic step(bit c, bit d, bit s, bit [3:0] p, string tag);
        clr2_n = c; dec_en = d; sys = s; sense_pulse = p;
        #1;
        compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic frame_cycle(int ph, bit [3:0] p, string tag);
        step(ph != 5, ph >= 8 && ph <= 10, ph == 10, p, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int en_hits[4];
        model_reset();
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 4'hF, "reset R9");
        rst_n = 1'b1;

        // R1: walk the select with dec_en held high
        for (int i = 0; i < 40; i++)
            step((i % 5) != 2, 1'b1, 1'b0, 4'h0, "select walk R1");
        // R3: enables quiet with dec_en low, strobes still arriving
        for (int i = 0; i < 20; i++)
            step((i % 4) != 1, 1'b0, 1'b0, 4'h0, "idle R3");

        // R4/R5/R6: framed scan with random pulses
        for (int f = 0; f < 4; f++)
            for (int ph = 0; ph < 16; ph++) frame_cycle(ph, 4'($urandom), "frame R5");

        // R4: 64-clock window, frame aligned
        foreach (en_hits[k]) en_hits[k] = 0;
        for (int f = 0; f < 4; f++)
            for (int ph = 0; ph < 16; ph++) begin
                frame_cycle(ph, 4'($urandom), "window R4");
                for (int k = 0; k < 4; k++) if (sense_en[k]) en_hits[k]++;
            end
        for (int k = 0; k < 4; k++) begin
            checks++;
            if (en_hits[k] != 3) begin
                errors++;
                $display("FAIL R4 sensor %0d enable clocks actual %0d expected 3", k, en_hits[k]);
            end
        end

        // R5: only one sensor pulses; sys held high
        for (int i = 0; i < 48; i++)
            step((i % 12) != 3, 1'b0, 1'b1, 4'b0100, "single sensor R5");

        // R6/R7/R8: steady pulses and sys to saturate the counter
        for (int i = 0; i < 60; i++)
            step((i % 16) != 7, 1'b1, 1'b1, 4'hF, "saturate R8");
        checks++;
        if (int'(pulse_count) != MAXC) begin
            errors++;
            $display("FAIL R8 pulse_count actual %0d expected %0d", pulse_count, MAXC);
        end

        // R9: reset in mid-run
        rst_n = 1'b0;
        step(1'b1, 1'b0, 1'b1, 4'hF, "reset R9");
        step(1'b1, 1'b1, 1'b1, 4'hF, "reset R9");
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++)
            step((i % 7) != 0, i[0], i[1], 4'($urandom), "after reset R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule